// File: doc/BRIEF.md
# Click-Phased Packet Receive Port

This block sits between a receive packet FIFO and a microcoded processor whose microinstructions run in atomic groups of three cycles, called clicks. The processor reads received words through a single read-data function placed on its bus. Whether that read consumes a FIFO entry depends on the click phase. Only a read made in the middle cycle of a click pops a new word into a holding register. A read made in the first or last cycle returns the word that is already held. Microcode whose memory store was aborted can therefore fetch the same word again without dropping it from the packet.

The port keeps its own click phase counter. A resynchronising input marks the current cycle as the first of a click. The FIFO is show-ahead: the head word and its end-of-packet tag are valid whenever the FIFO is not empty. The port also drives a two-bit dispatch status. The low bit is an attention flag. It rises when the last word of a packet is consumed, when the hardware reports an error, or when a middle-cycle read finds the FIFO empty. The high bit tells the microcode whether a controller is fitted. A parameter selects a stand-in variant for a missing controller.

Top module: `rx_click_port`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `rd_data` is zero, `status` is 2'b00 (present variant), `fifo_pop` is low, and the click phase is cycle 1.
- R2: The click phase runs 1, 2, 3, 1, ... on successive cycles. A cycle with `click_first` high is treated as cycle 1, and the next cycle is cycle 2.
- R3: A read (`rd_strobe` high) in cycle 2 with the FIFO not empty raises `fifo_pop` for that cycle. The head word appears on `rd_data` in the same cycle and stays there until the next pop.
- R4: A read in cycle 1 or cycle 3 does not pop and returns the held word on `rd_data`.
- R5: With `rd_strobe` low the FIFO is never popped and `rd_data` shows the held word.
- R6: Popping a word whose `fifo_eop` tag is 1 sets `status[0]` from the next cycle.
- R7: `hw_error` high in a cycle sets `status[0]` from the next cycle.
- R8: A read in cycle 2 with the FIFO empty does not pop and leaves the held word unchanged. It sets a sticky underrun condition that drives `status[0]` high from the next cycle.
- R9: `ack` high clears `status[0]` (attention and underrun) from the next cycle. A set event in the same cycle wins over `ack`.
- R10: With `PRESENT=1`, `status[1]` is 0. With `PRESENT=0`, `status` is constantly 2'b10 and the FIFO is never popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| click_first | input | 1 | Marks the current cycle as cycle 1 of a click |
| fifo_empty | input | 1 | Receive FIFO holds no word |
| fifo_word | input | DATA_W | Head word of the FIFO (show-ahead) |
| fifo_eop | input | 1 | Head word is the last of its packet |
| fifo_pop | output | 1 | Consume the head word this cycle |
| rd_strobe | input | 1 | Processor uses the read-data function this cycle |
| hw_error | input | 1 | Hardware error event |
| ack | input | 1 | Clears the attention and underrun conditions |
| rd_data | output | DATA_W | Word presented to the processor bus |
| status | output | 2 | Dispatch status: bit 0 attention, bit 1 controller absent |

## Verification
The sweep runs a long arithmetic stimulus stream. Reads land in every click phase, the FIFO alternates between filled and drained stretches, and phase resynchronisation arrives at random points. A port that popped on the wrong phase would skip or repeat packet words, and the bench sees this as a wrong word on the bus. A port that loaded the holding register on an empty read would present stale FIFO data. A port that lost the sticky underrun, or let an acknowledge override a set event in the same cycle, would leave the attention bit low in a cycle where the model expects it high. The stand-in variant is run beside the real one so that its fixed status and idle FIFO interface are checked as well.

// File: rtl/rxp_pkg.sv
package rxp_pkg;

   typedef enum logic [1:0] {
      PH1 = 2'd1,
      PH2 = 2'd2,
      PH3 = 2'd3
   } phase_t;

   localparam int unsigned CLICK_LEN = 3;

endpackage

// File: rtl/rxp_phase_ctr.sv
module rxp_phase_ctr
   import rxp_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   click_first,
   output phase_t cur_phase,
   output phase_t phase_q
);

   phase_t next_phase;

   // A resync marks this cycle as the first of a click.
   assign cur_phase = click_first ? PH1 : phase_q;

   always_comb begin
      unique case (cur_phase)
         PH1:     next_phase = PH2;
         PH2:     next_phase = PH3;
         default: next_phase = PH1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= PH1;
      else        phase_q <= next_phase;
   end

endmodule

// File: rtl/rxp_hold_reg.sv
module rxp_hold_reg #(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);

   logic [DATA_W-1:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    hold_q <= '0;
      else if (load) hold_q <= din;
   end

   // The popped word passes straight to the bus in its own cycle.
   assign dout = load ? din : hold_q;

endmodule

// File: rtl/rxp_attn.sv
module rxp_attn (
   input  logic clk,
   input  logic rst_n,
   input  logic eop_pop,
   input  logic hw_error,
   input  logic underrun,
   input  logic ack,
   output logic attn
);

   logic event_q;
   logic under_q;

   // A set event in the same cycle wins over the acknowledge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         event_q <= 1'b0;
         under_q <= 1'b0;
      end else begin
         if (eop_pop || hw_error) event_q <= 1'b1;
         else if (ack)            event_q <= 1'b0;
         if (underrun)            under_q <= 1'b1;
         else if (ack)            under_q <= 1'b0;
      end
   end

   assign attn = event_q | under_q;

endmodule

// File: rtl/rx_click_port.sv
module rx_click_port
   import rxp_pkg::*;
#(
   parameter int unsigned DATA_W  = 16,
   parameter bit          PRESENT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              click_first,
   input  logic              fifo_empty,
   input  logic [DATA_W-1:0] fifo_word,
   input  logic              fifo_eop,
   output logic              fifo_pop,
   input  logic              rd_strobe,
   input  logic              hw_error,
   input  logic              ack,
   output logic [DATA_W-1:0] rd_data,
   output logic [1:0]        status
);

   localparam int unsigned STATUS_W = 2;

   if (DATA_W < 1) begin : g_bad_width
      $error("rx_click_port: DATA_W must be at least 1");
   end
   if (STATUS_W != 2) begin : g_bad_status
      $error("rx_click_port: dispatch status must be two bits");
   end

   phase_t cur_phase;
   phase_t phase_q;
   logic   rd_en;
   logic   mid_read;
   logic   underrun;
   logic   attn;

   rxp_phase_ctr u_phase (
      .clk         (clk),
      .rst_n       (rst_n),
      .click_first (click_first),
      .cur_phase   (cur_phase),
      .phase_q     (phase_q)
   );

   // The stand-in variant never touches the FIFO.
   assign rd_en    = PRESENT ? rd_strobe : 1'b0;
   assign mid_read = rd_en && (cur_phase == PH2);
   assign fifo_pop = mid_read && !fifo_empty;
   assign underrun = mid_read && fifo_empty;

   rxp_hold_reg #(.DATA_W(DATA_W)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (fifo_pop),
      .din   (fifo_word),
      .dout  (rd_data)
   );

   rxp_attn u_attn (
      .clk      (clk),
      .rst_n    (rst_n),
      .eop_pop  (fifo_pop && fifo_eop),
      .hw_error (hw_error),
      .underrun (underrun),
      .ack      (ack),
      .attn     (attn)
   );

   if (PRESENT) begin : g_present
      assign status = {1'b0, attn};
   end else begin : g_absent
      logic unused_attn;
      assign unused_attn = attn;
      assign status      = 2'b10;
   end

endmodule

// File: rtl/rx_click_port_chk.sv
module rx_click_port_chk
   import rxp_pkg::*;
#(
   parameter int unsigned DATA_W  = 16,
   parameter bit          PRESENT = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              click_first,
   input logic              rd_strobe,
   input logic              fifo_empty,
   input logic              fifo_eop,
   input logic              fifo_pop,
   input logic              hw_error,
   input logic              ack,
   input logic [DATA_W-1:0] rd_data,
   input logic [1:0]        status,
   input phase_t            cur_phase,
   input phase_t            phase_q
);

   assert_resync_R2: assert property (@(posedge clk) disable iff (!rst_n)
      click_first |-> (cur_phase == PH1));

   assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_phase == PH1) |=> (phase_q == PH2));

   assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_phase == PH3) |=> (phase_q == PH1));

   assert_pop_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |-> (rd_strobe && (cur_phase == PH2) && !fifo_empty));

   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!fifo_pop ##1 !fifo_pop) |-> $stable(rd_data));

   assert_eop_attn_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_pop && fifo_eop) |=> status[0]);

   assert_hwerr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (PRESENT && hw_error) |=> status[0]);

   assert_underrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (PRESENT && rd_strobe && (cur_phase == PH2) && fifo_empty) |=> status[0]);

   assert_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !hw_error && !(rd_strobe && (cur_phase == PH2))) |=> !status[0]);

   assert_variant_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (status[1] == !PRESENT) && (PRESENT || !fifo_pop));

endmodule

bind rx_click_port rx_click_port_chk #(.DATA_W(DATA_W), .PRESENT(PRESENT)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .click_first (click_first),
   .rd_strobe   (rd_strobe),
   .fifo_empty  (fifo_empty),
   .fifo_eop    (fifo_eop),
   .fifo_pop    (fifo_pop),
   .hw_error    (hw_error),
   .ack         (ack),
   .rd_data     (rd_data),
   .status      (status),
   .cur_phase   (cur_phase),
   .phase_q     (phase_q)
);

// File: tb/sim_rx_click_port.sv
module sim_rx_click_port;

   localparam int DW = 16;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n, click_first, rd_strobe, hw_error, ack;
   logic          fifo_empty, fifo_eop;
   logic [DW-1:0] fifo_word;
   logic          pop0, pop1;
   logic [DW-1:0] rd0, rd1;
   logic [1:0]    st0, st1;

   int rd_idx, wr_idx;
   int checks   = 0;
   int failures = 0;
   bit done     = 0;

   function automatic logic [DW-1:0] wordf(input int i);
      return 16'h5A00 ^ 16'(i * 37);
   endfunction

   always_comb begin
      fifo_empty = (rd_idx >= wr_idx);
      fifo_word  = wordf(rd_idx);
      fifo_eop   = ((rd_idx % 5) == 4);
   end

   rx_click_port #(.DATA_W(DW), .PRESENT(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .click_first(click_first),
      .fifo_empty(fifo_empty), .fifo_word(fifo_word), .fifo_eop(fifo_eop),
      .fifo_pop(pop0), .rd_strobe(rd_strobe), .hw_error(hw_error), .ack(ack),
      .rd_data(rd0), .status(st0));

   rx_click_port #(.DATA_W(DW), .PRESENT(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .click_first(click_first),
      .fifo_empty(fifo_empty), .fifo_word(fifo_word), .fifo_eop(fifo_eop),
      .fifo_pop(pop1), .rd_strobe(rd_strobe), .hw_error(hw_error), .ack(ack),
      .rd_data(rd1), .status(st1));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] hold;
      logic          st;
      int            ph;
      logic [15:0]   lfsr;
      string         st_tag;

      rst_n = 1'b0; click_first = 0; rd_strobe = 0; hw_error = 0; ack = 0;
      rd_idx = 0; wr_idx = 0;
      repeat (3) @(negedge clk);
      #1;
      chk("R1 rd_data in reset", 32'(rd0), 0);
      chk("R1 status in reset", 32'(st0), 0);
      chk("R1 pop in reset", 32'(pop0), 0);
      chk("R10 absent status in reset", 32'(st1), 32'h2);

      @(negedge clk);
      rst_n = 1'b1;
      hold = '0; st = 1'b0; ph = 1; lfsr = 16'hACE1; st_tag = "R1";

      for (int i = 0; i < 3000; i++) begin
         int            cur;
         logic          exp_pop, under, eop, set;
         logic [DW-1:0] exp_rd;
         string         tg;

         lfsr        = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         rd_strobe   = lfsr[0] | lfsr[1];
         click_first = (lfsr[6:2] == 5'd0);
         hw_error    = (lfsr[11:7] == 5'h1F);
         ack         = (lfsr[14:12] == 3'd0);
         if (((i % 40) < 22) && ((i % 2) == 0)) wr_idx++;
         #1;

         cur     = click_first ? 1 : ph;
         exp_pop = rd_strobe && (cur == 2) && !fifo_empty;
         under   = rd_strobe && (cur == 2) && fifo_empty;
         eop     = exp_pop && ((rd_idx % 5) == 4);
         exp_rd  = exp_pop ? wordf(rd_idx) : hold;

         if (click_first)      tg = "R2";
         else if (!rd_strobe)  tg = "R5";
         else if (cur != 2)    tg = "R4";
         else if (fifo_empty)  tg = "R8";
         else                  tg = "R3";

         chk({tg, " pop"}, 32'(pop0), 32'(exp_pop));
         chk({tg, " rd_data"}, 32'(rd0), 32'(exp_rd));
         chk({st_tag, " status attention"}, 32'(st0[0]), 32'(st));
         chk("R10 present status high bit", 32'(st0[1]), 0);
         chk("R10 absent status", 32'(st1), 32'h2);
         chk("R10 absent pop", 32'(pop1), 0);

         set = eop || hw_error || under;
         if (eop)                  st_tag = "R6";
         else if (hw_error)        st_tag = "R7";
         else if (under)           st_tag = "R8";
         else if (ack && st)       st_tag = "R9";

         @(posedge clk);
         #1;
         if (exp_pop) begin
            hold = wordf(rd_idx);
            rd_idx++;
         end
         st = set ? 1'b1 : (ack ? 1'b0 : st);
         ph = (cur == 3) ? 1 : cur + 1;
         @(negedge clk);
      end

      done = 1;
      summary();
      $finish;
   end

endmodule